// File: doc/BRIEF.md
# Bus-Activity Watchdog and Reset Supervisor

This block produces a single system reset from two sources: a low-supply flag supplied by an external comparator, and a watchdog that watches the chip-select line of a serial bus. A host that is running normally keeps selecting the bus, and each new selection restarts the watchdog. If chip-select sits at one level for longer than the chosen period, whether that level is high or low, the block asserts reset. A two-bit code chooses roughly 1.4 s, 600 ms or 200 ms, or turns the watchdog off.

Each reset cause keeps the output active for a recovery hold of about 200 ms. The causes are power-on, a supply fault and a watchdog expiry. A supply fault holds reset for as long as the supply stays low, and the hold starts counting only after the supply has returned. Every interval is written in milliseconds and converted to clock cycles by a cycles-per-millisecond parameter, so a test can shrink all of them together. A parameter sets the polarity of the output, and the timing is the same for both polarities.

Top module: `wdsup_top`

## Requirements
- R1: While `rst` is high the reset output is active. After `rst` falls, the output stays active for exactly HOLD = HOLD_MS*TICKS_PER_MS rising edges and goes inactive on the HOLD-th edge.
- R2: The watchdog limit L in cycles depends on `wd_sel`: 2'b00 gives LONG_MS*TICKS_PER_MS, 2'b01 gives MID_MS*TICKS_PER_MS and 2'b10 gives SHORT_MS*TICKS_PER_MS.
- R3: Only a falling edge of `cs_n`, seen after a two-flop synchronizer, restarts the watchdog. If `cs_n` goes low between edges and nothing else happens, reset becomes active on the (L+3)-th rising edge and not earlier. Falling edges spaced less than L apart keep reset inactive.
- R4: A rising edge of `cs_n` does not restart the watchdog, so holding `cs_n` high after a short low pulse fires reset with the same L+3 timing.
- R5: `wd_sel` = 2'b11 turns the watchdog off. Reset then never fires, however long `cs_n` stays still.
- R6: A high `supply_low` makes reset active on the next rising edge and keeps it active. After `supply_low` falls, reset stays active for HOLD-1 more edges and releases on the HOLD-th edge.
- R7: A watchdog expiry keeps reset active for HOLD edges: it becomes inactive HOLD edges after the edge on which it became active.
- R8: A supply fault during a watchdog reset extends that reset. The HOLD interval starts again from the edge after `supply_low` falls.
- R9: The watchdog count is cleared while reset is active. After a reset releases, a still `cs_n` fires again only after L full cycles.
- R10: With ACTIVE_LOW=1 the output is low while reset is active. With ACTIVE_LOW=0 it is high while reset is active. The timing is identical in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_low | input | 1 | Synchronous flag from the supply comparator, high when below trip |
| cs_n | input | 1 | Bus chip-select, asynchronous to clk |
| wd_sel | input | 2 | Watchdog period select (00 long, 01 mid, 10 short, 11 off) |
| rst_out | output | 1 | System reset, polarity set by ACTIVE_LOW |

## Verification
The bench samples the output exactly one edge before and exactly one edge at each expected transition. A synchronizer that is one stage short or long, or a counter that is off by one, therefore shows up as a mismatch and is not hidden by slack. It holds chip-select high after a short pulse to catch a design that restarts on any edge, since such a design would never time out. It lets a watchdog reset release while chip-select is still idle: a counter that was not cleared during reset would fire again almost at once. It also drops the supply partway through a watchdog hold, where a design that merely finished the old hold would release too early.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    // Watchdog period selection as held in the status register
    typedef enum logic [1:0] {
        SEL_LONG  = 2'b00,
        SEL_MID   = 2'b01,
        SEL_SHORT = 2'b10,
        SEL_OFF   = 2'b11
    } wd_sel_e;

    // Reset sequencer state; every state except ST_RUN drives reset
    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_BROWN = 2'd1,
        ST_WDOG  = 2'd2,
        ST_RUN   = 2'd3
    } sup_state_e;

    // Limit and enable for the chosen watchdog period
    typedef struct packed {
        logic        enabled;
        logic [31:0] limit;
    } wd_cfg_t;

    function automatic longint unsigned ms_to_ticks(input longint unsigned ms,
                                                    input longint unsigned tpm);
        return ms * tpm;
    endfunction

    function automatic longint unsigned max3(input longint unsigned a,
                                             input longint unsigned b,
                                             input longint unsigned c);
        longint unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdsup_cs_sync.sv
module wdsup_cs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic cs_fall
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Shift toward the MSB; chip-select idles high so the chain resets to ones
    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '1;
            prev_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], cs_n};
            prev_q <= chain[STAGES-1];
        end
    end

    assign cs_fall = prev_q & ~chain[STAGES-1];

    // R3: a falling edge is a single-cycle event
    p_fall_single_r3: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> !cs_fall);

endmodule

// File: rtl/wdsup_watchdog.sv
module wdsup_watchdog
    import wdsup_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 1000,
    parameter int unsigned LONG_MS      = 1400,
    parameter int unsigned MID_MS       = 600,
    parameter int unsigned SHORT_MS     = 200
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  logic    kick,
    input  wd_sel_e sel,
    output logic    expire
);
    localparam longint unsigned LIM_LONG  = ms_to_ticks(LONG_MS,  TICKS_PER_MS);
    localparam longint unsigned LIM_MID   = ms_to_ticks(MID_MS,   TICKS_PER_MS);
    localparam longint unsigned LIM_SHORT = ms_to_ticks(SHORT_MS, TICKS_PER_MS);
    localparam longint unsigned LIM_MAX   = max3(LIM_LONG, LIM_MID, LIM_SHORT);
    localparam int              CW        = $clog2(LIM_MAX + 1);

    wd_cfg_t       cfg;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Period decode
    always_comb begin
        cfg = '0;
        unique case (sel)
            SEL_LONG:  cfg = '{enabled: 1'b1, limit: 32'(LIM_LONG)};
            SEL_MID:   cfg = '{enabled: 1'b1, limit: 32'(LIM_MID)};
            SEL_SHORT: cfg = '{enabled: 1'b1, limit: 32'(LIM_SHORT)};
            SEL_OFF:   cfg = '{enabled: 1'b0, limit: 32'd0};
            default:   cfg = '0;
        endcase
        lim = CW'(cfg.limit);
    end

    // Greater-or-equal keeps a mid-count switch to a shorter period safe
    assign expire = cfg.enabled && !hold && !kick && (cnt >= lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || hold || kick || !cfg.enabled || expire)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // R5: a disabled watchdog keeps its count at zero
    p_off_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_OFF) |=> (cnt == '0));

    // R9: the count is cleared while reset is active
    p_hold_clear_r9: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt == '0));

    // R3: a restart cannot be followed at once by an expiry
    p_kick_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (kick && sel == $past(sel) && lim > CW'(2)) |=> !expire);

endmodule

// File: rtl/wdsup_reset_seq.sv
module wdsup_reset_seq
    import wdsup_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 1000,
    parameter int unsigned HOLD_MS      = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_low,
    input  logic       wd_expire,
    output sup_state_e state,
    output logic       active
);
    localparam longint unsigned HOLD_TICKS = ms_to_ticks(HOLD_MS, TICKS_PER_MS);
    localparam int              HW         = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_POR;
            hold_cnt <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    hold_cnt <= '0;
                    if (supply_low)
                        state <= ST_BROWN;
                    else if (wd_expire)
                        state <= ST_WDOG;
                end
                default: begin
                    if (supply_low) begin
                        state    <= ST_BROWN;
                        hold_cnt <= '0;
                    end else if (hold_cnt == HW'(HOLD_TICKS - 1)) begin
                        state    <= ST_RUN;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + HW'(1);
                    end
                end
            endcase
        end
    end

    assign active = (state != ST_RUN);

    // R1: the hold counter never reaches the hold length
    p_hold_range_r1: assert property (@(posedge clk) disable iff (rst)
        hold_cnt < HW'(HOLD_TICKS));

    // R6: a supply fault forces reset on the following edge
    p_brown_next_r6: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> active);

    // R8: reset never releases on an edge that saw the supply low
    p_release_clean_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> !$past(supply_low));

endmodule

// File: rtl/wdsup_top.sv
module wdsup_top
    import wdsup_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 1000,
    parameter int unsigned LONG_MS      = 1400,
    parameter int unsigned MID_MS       = 600,
    parameter int unsigned SHORT_MS     = 200,
    parameter int unsigned HOLD_MS      = 200,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter bit          ACTIVE_LOW   = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_low,
    input  logic       cs_n,
    input  logic [1:0] wd_sel,
    output logic       rst_out
);
    logic       cs_fall;
    logic       wd_expire;
    logic       active;
    sup_state_e state;

    wdsup_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .cs_fall (cs_fall)
    );

    wdsup_watchdog #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .LONG_MS      (LONG_MS),
        .MID_MS       (MID_MS),
        .SHORT_MS     (SHORT_MS)
    ) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .hold   (active),
        .kick   (cs_fall),
        .sel    (wd_sel_e'(wd_sel)),
        .expire (wd_expire)
    );

    wdsup_reset_seq #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .HOLD_MS      (HOLD_MS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .supply_low (supply_low),
        .wd_expire  (wd_expire),
        .state      (state),
        .active     (active)
    );

    generate
        if (ACTIVE_LOW) begin : g_pol_low
            assign rst_out = ~active;
        end else begin : g_pol_high
            assign rst_out = active;
        end
    endgenerate

    // R3: an expiry while running with a good supply moves to the watchdog hold
    p_fire_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && wd_expire && !supply_low) |=> (state == ST_WDOG));

    // R7: the watchdog hold only exits to running or to a supply fault
    p_wdog_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDOG) |=> (state inside {ST_WDOG, ST_RUN, ST_BROWN}));

endmodule

// File: tb/sim_wdsup_top.sv
module sim_wdsup_top;
    localparam int TPM   = 2;
    localparam int L_LNG = 1400 * TPM;
    localparam int L_MID = 600 * TPM;
    localparam int L_SHT = 200 * TPM;
    localparam int HOLD  = 200 * TPM;

    // Vector table: select code, edges after cs_n falls, short pulse, expected reset
    localparam int NV = 8;
    localparam int TV_SEL   [NV] = '{2, 2, 1, 1, 0, 0, 3, 2};
    localparam int TV_EDGES [NV] = '{L_SHT+2, L_SHT+3, L_MID+2, L_MID+3,
                                     L_LNG+2, L_LNG+3, 3000, L_SHT+3};
    localparam int TV_PULSE [NV] = '{0, 0, 0, 0, 0, 0, 0, 1};
    localparam int TV_EXP   [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_low = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] wd_sel = 2'b10;
    logic       out_lo;
    logic       out_hi;
    int         errors = 0;
    int         checks = 0;

    always #5 clk = ~clk;

    wdsup_top #(.TICKS_PER_MS(TPM), .ACTIVE_LOW(1'b1)) u0 (
        .clk(clk), .rst(rst), .supply_low(supply_low), .cs_n(cs_n),
        .wd_sel(wd_sel), .rst_out(out_lo));

    wdsup_top #(.TICKS_PER_MS(TPM), .ACTIVE_LOW(1'b0)) u1 (
        .clk(clk), .rst(rst), .supply_low(supply_low), .cs_n(cs_n),
        .wd_sel(wd_sel), .rst_out(out_hi));

    // Checks both polarities against the expected reset state (R10)
    task automatic expect_rst(input string req, input bit exp_active);
        checks++;
        if (out_lo !== ~exp_active) begin
            errors++;
            $display("FAIL %s (R10 low pol): rst_out=%b expected=%b at %0t",
                     req, out_lo, ~exp_active, $time);
        end
        checks++;
        if (out_hi !== exp_active) begin
            errors++;
            $display("FAIL %s (R10 high pol): rst_out=%b expected=%b at %0t",
                     req, out_hi, exp_active, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Power-on sequence ending at the first running cycle
    task automatic power_on(input logic [1:0] sel);
        @(negedge clk);
        rst = 1'b1; supply_low = 1'b0; cs_n = 1'b1; wd_sel = sel;
        edges(3);
        rst = 1'b0;
        edges(HOLD);
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: simulation hung");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state and power-on hold length
        edges(2);
        expect_rst("R1 during rst", 1'b1);
        rst = 1'b0;
        edges(HOLD - 1);
        expect_rst("R1 hold edge-1", 1'b1);
        edges(1);
        expect_rst("R1 hold release", 1'b0);

        // Table walk: R2 periods, R3 timing, R4 held high, R5 off
        for (int i = 0; i < NV; i++) begin
            power_on(2'(TV_SEL[i]));
            cs_n = 1'b0;
            for (int k = 0; k < TV_EDGES[i]; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (k == 0 && TV_PULSE[i] != 0) cs_n = 1'b1;
            end
            if (TV_PULSE[i] != 0)
                expect_rst("R4 held high fires", TV_EXP[i] != 0);
            else if (TV_SEL[i] == 3)
                expect_rst("R5 disabled", TV_EXP[i] != 0);
            else
                expect_rst("R2/R3 period vector", TV_EXP[i] != 0);
        end

        // R3: regular kicks keep reset away
        power_on(2'b10);
        for (int j = 0; j < 6; j++) begin
            cs_n = 1'b1;
            edges(5);
            cs_n = 1'b0;
            edges(295);
            expect_rst("R3 kicked stays running", 1'b0);
        end

        // R6: supply fault and recovery
        power_on(2'b11);
        supply_low = 1'b1;
        edges(1);
        expect_rst("R6 fault next edge", 1'b1);
        edges(30);
        expect_rst("R6 fault held", 1'b1);
        supply_low = 1'b0;
        edges(HOLD - 1);
        expect_rst("R6 recovery edge-1", 1'b1);
        edges(1);
        expect_rst("R6 recovery release", 1'b0);

        // R7 and R9: watchdog hold length, then a full fresh period
        power_on(2'b10);
        cs_n = 1'b0;
        edges(L_SHT + 3);
        expect_rst("R7 fired", 1'b1);
        edges(HOLD - 1);
        expect_rst("R7 hold edge-1", 1'b1);
        edges(1);
        expect_rst("R7 hold release", 1'b0);
        edges(L_SHT - 1);
        expect_rst("R9 cleared count edge-1", 1'b0);
        edges(1);
        expect_rst("R9 refire after full period", 1'b1);

        // R8: supply fault inside a watchdog hold restarts recovery
        power_on(2'b10);
        cs_n = 1'b0;
        edges(L_SHT + 3);
        edges(100);
        supply_low = 1'b1;
        edges(20);
        supply_low = 1'b0;
        edges(HOLD - 1);
        expect_rst("R8 extended edge-1", 1'b1);
        edges(1);
        expect_rst("R8 extended release", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule